// File: doc/BRIEF.md
# Segmented-Paging Address Translator with Direct-Mapped Translation Cache

This block turns a 16-bit byte virtual address into a 16-bit physical address. The top three virtual bits pick one of eight equal segments. An on-chip table holds, for each segment, the physical address where that segment's page table starts in main memory. Pages are 512 bytes, so the low nine address bits pass through unchanged and the remaining seven bits form the virtual page number. That number is the 3-bit segment followed by a 4-bit page index.

A 16-slot direct-mapped cache holds recent translations. Its slot index is the low four bits of the virtual page number and its tag is the upper three. A request that hits is answered one cycle later. On a miss, the block reads the 16-bit page table entry through a halfword read port at segment base + 2 × page index. It checks the valid and permission bits, answers the request, and caches the entry when the access is allowed.

Software loads the segment bases through a write port. Each such write drops every cached translation that belongs to the rewritten segment.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_rd_en` are 0 and no translation is cached, so the first access to any page performs a table read.
- R2: A request accepted while idle whose page is cached gets its response (`rsp_valid` = 1) on the first clock edge after acceptance. `rsp_paddr` = {cached frame, vaddr[8:0]} and no memory read is issued.
- R3: On a miss, `mem_rd_en` is raised with `mem_rd_addr` = base[vaddr[15:13]] + 2·vaddr[12:9]. The address is held stable until `mem_rd_valid`.
- R4: The page table entry layout is frame [15:9], valid [8], permissions [7:5] (bit 7 read, bit 6 write, bit 5 execute), dirty [4] and aging [3:0]. Dirty and aging bits do not affect translation. Access codes on `req_acc` are 00 read, 01 write and 10 execute; code 11 always faults.
- R5: A valid entry that permits the access yields `rsp_fault` = 0 and `rsp_paddr` = {frame, offset}. The response comes one cycle after `mem_rd_valid` and is three cycles after acceptance with a one-cycle memory. The entry is cached, so a later access to the same page hits.
- R6: An entry with valid = 0 yields `rsp_fault` = 1 and is not cached; a repeat access reads memory again.
- R7: An access whose permission bit is 0 faults. This applies on a hit (answered from the cache, no read) and on a miss (entry not cached).
- R8: Two pages with equal page index but different segment share one slot and evict each other.
- R9: A segment base write invalidates all cached pages of that segment and leaves pages of other segments cached.
- R10: While `busy` = 1, `req_valid` is ignored. The request is neither answered nor translated later.
- R11: If the base of the segment being walked is written during the walk, the response still uses the entry fetched, but that entry is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when not busy |
| req_vaddr | input | 16 | Virtual byte address |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute |
| busy | output | 1 | Table walk in progress; requests ignored |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Invalid entry or permission denied |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| mem_rd_en | output | 1 | Halfword read request for page table entry |
| mem_rd_addr | output | 16 | Byte address of the page table entry |
| mem_rd_valid | input | 1 | Read data valid, completes the read |
| mem_rd_data | input | 16 | Page table entry read |
| seg_wr_en | input | 1 | Segment base write strobe |
| seg_wr_sel | input | 3 | Segment whose base is written |
| seg_wr_base | input | 16 | New page-table base address |

## Verification
Directed accesses are used first. A cold miss followed by a hit to the same page at another offset separates the walk path from the cached path by latency and read count. Entries with valid cleared, or with a single permission bit, are tried under read, write, execute and the reserved code. This shows whether faults come from the cache or from memory, and whether a faulting entry was cached. Two pages sharing a slot across segments exercise eviction. A base rewrite of one segment, checked against a cached page of another segment, shows the flush is selective. A second request during a walk, and a base rewrite in the middle of a walk, check that nothing is accepted or cached out of turn.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

  typedef enum logic { ST_IDLE = 1'b0, ST_WALK = 1'b1 } walk_st_e;

  localparam logic [1:0] ACC_READ  = 2'b00;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_EXEC  = 2'b10;

  localparam int PERM_W = 3;

  // permission bits: [2] read, [1] write, [0] execute; code 11 never allowed
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                       input logic [1:0] acc);
    case (acc)
      ACC_READ:  return perm[2];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[0];
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mmu_seg_table.sv
module mmu_seg_table #(
  parameter int SEG_W = 3,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_sel,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [SEG_W-1:0] rd_sel,
  output logic [PA_W-1:0]  rd_base
);
  localparam int NSEG = 1 << SEG_W;

  logic [PA_W-1:0] base_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n)                               base_q[s] <= '0;
      else if (wr_en && wr_sel == SEG_W'(s))    base_q[s] <= wr_base;
    end
  end

  assign rd_base = base_q[rd_sel];

endmodule

// File: rtl/mmu_tlb_dm.sv
module mmu_tlb_dm #(
  parameter int VPN_W   = 7,
  parameter int IDX_W   = 4,
  parameter int SEG_W   = 3,
  parameter int FRAME_W = 7,
  parameter int PERM_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic [PERM_W-1:0]  lk_perm,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [PERM_W-1:0]  fill_perm,
  input  logic               flush_en,
  input  logic [SEG_W-1:0]   flush_seg
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = VPN_W - IDX_W;

  logic [DEPTH-1:0]   vld_q;
  logic [TAG_W-1:0]   tag_q   [DEPTH];
  logic [FRAME_W-1:0] frame_q [DEPTH];
  logic [PERM_W-1:0]  perm_q  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [VPN_W-1:0] slot_vpn;
    logic             fill_here;
    logic             flush_here;

    assign slot_vpn   = {tag_q[i], IDX_W'(i)};
    assign fill_here  = fill_en && fill_vpn[IDX_W-1:0] == IDX_W'(i);
    assign flush_here = flush_en && vld_q[i] &&
                        slot_vpn[VPN_W-1 -: SEG_W] == flush_seg;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i]   <= 1'b0;
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
        perm_q[i]  <= '0;
      end else if (fill_here) begin
        vld_q[i]   <= 1'b1;
        tag_q[i]   <= fill_vpn[VPN_W-1:IDX_W];
        frame_q[i] <= fill_frame;
        perm_q[i]  <= fill_perm;
      end else if (flush_here) begin
        vld_q[i]   <= 1'b0;
      end
    end

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_here && !fill_here) |=> !vld_q[i]);
  end

  logic [IDX_W-1:0] lk_idx;
  assign lk_idx   = lk_vpn[IDX_W-1:0];
  assign lk_hit   = vld_q[lk_idx] && tag_q[lk_idx] == lk_vpn[VPN_W-1:IDX_W];
  assign lk_frame = frame_q[lk_idx];
  assign lk_perm  = perm_q[lk_idx];

  p_fill_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_en) |=> vld_q[$past(fill_vpn[IDX_W-1:0])]);

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PA_W      = 16,
  parameter int OFF_W     = 9,
  parameter int SEG_W     = 3,
  parameter int TLB_IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_rd_en,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [15:0]      mem_rd_data,
  input  logic             seg_wr_en,
  input  logic [SEG_W-1:0] seg_wr_sel,
  input  logic [PA_W-1:0]  seg_wr_base
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PGIDX_W = VPN_W - SEG_W;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int PTE_W   = 16;
  localparam int V_POS   = PTE_W - FRAME_W - 1;
  localparam int P_HI    = V_POS - 1;

  function automatic logic [PA_W-1:0] pte_addr(input logic [PA_W-1:0] base,
                                               input logic [PGIDX_W-1:0] pidx);
    return base + (PA_W'(pidx) << 1);
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [VA_W-1:0] va);
    return {frame, va[OFF_W-1:0]};
  endfunction

  walk_st_e        state_q;
  logic [VA_W-1:0] sv_vaddr_q;
  logic [1:0]      sv_acc_q;
  logic [PA_W-1:0] walk_addr_q;
  logic            stale_q;
  logic            rsp_valid_q, rsp_fault_q;
  logic [PA_W-1:0] rsp_paddr_q;

  logic [VPN_W-1:0]   req_vpn, sv_vpn;
  logic [SEG_W-1:0]   req_seg, sv_seg;
  logic [PGIDX_W-1:0] req_pidx;
  logic [PA_W-1:0]    seg_base;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic [PERM_W-1:0]  lk_perm;

  assign req_vpn  = req_vaddr[VA_W-1:OFF_W];
  assign req_seg  = req_vpn[VPN_W-1 -: SEG_W];
  assign req_pidx = req_vpn[PGIDX_W-1:0];
  assign sv_vpn   = sv_vaddr_q[VA_W-1:OFF_W];
  assign sv_seg   = sv_vpn[VPN_W-1 -: SEG_W];

  // named events for assertions
  logic req_fire, hit_fire, miss_fire, walk_done, pte_ok, stale_now, fill_en;
  logic [FRAME_W-1:0] pte_frame;
  logic               pte_valid;
  logic [PERM_W-1:0]  pte_perm;

  assign pte_frame = mem_rd_data[PTE_W-1 -: FRAME_W];
  assign pte_valid = mem_rd_data[V_POS];
  assign pte_perm  = mem_rd_data[P_HI -: PERM_W];

  assign req_fire  = req_valid && state_q == ST_IDLE;
  assign hit_fire  = req_fire && lk_hit;
  assign miss_fire = req_fire && !lk_hit;
  assign walk_done = state_q == ST_WALK && mem_rd_valid;
  assign pte_ok    = pte_valid && perm_allows(pte_perm, sv_acc_q);
  assign stale_now = stale_q || (seg_wr_en && seg_wr_sel == sv_seg);
  assign fill_en   = walk_done && pte_ok && !stale_now;

  mmu_seg_table #(.SEG_W(SEG_W), .PA_W(PA_W)) u_seg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_base(seg_wr_base),
    .rd_sel(req_seg), .rd_base(seg_base)
  );

  mmu_tlb_dm #(.VPN_W(VPN_W), .IDX_W(TLB_IDX_W), .SEG_W(SEG_W),
               .FRAME_W(FRAME_W), .PERM_W(PERM_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_vpn(sv_vpn), .fill_frame(pte_frame), .fill_perm(pte_perm),
    .flush_en(seg_wr_en), .flush_seg(seg_wr_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sv_vaddr_q  <= '0;
      sv_acc_q    <= '0;
      walk_addr_q <= '0;
      stale_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (hit_fire) begin
        rsp_valid_q <= 1'b1;
        rsp_fault_q <= !perm_allows(lk_perm, req_acc);
        rsp_paddr_q <= perm_allows(lk_perm, req_acc) ? join_pa(lk_frame, req_vaddr) : '0;
      end
      if (miss_fire) begin
        state_q     <= ST_WALK;
        sv_vaddr_q  <= req_vaddr;
        sv_acc_q    <= req_acc;
        walk_addr_q <= pte_addr(seg_base, req_pidx);
        stale_q     <= seg_wr_en && seg_wr_sel == req_seg;
      end else if (state_q == ST_WALK) begin
        stale_q <= stale_now;
      end
      if (walk_done) begin
        state_q     <= ST_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_fault_q <= !pte_ok;
        rsp_paddr_q <= pte_ok ? join_pa(pte_frame, sv_vaddr_q) : '0;
      end
    end
  end

  assign busy        = state_q == ST_WALK;
  assign mem_rd_en   = state_q == ST_WALK;
  assign mem_rd_addr = walk_addr_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_fault   = rsp_fault_q;
  assign rsp_paddr   = rsp_paddr_q;

  p_hit_rsp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> rsp_valid);
  p_hit_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> !mem_rd_en);
  p_walk_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));
  p_bad_pte_faults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && !pte_ok) |=> (rsp_valid && rsp_fault));
  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_done) |=> !rsp_valid);
  p_stale_no_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && seg_wr_en && seg_wr_sel == sv_seg) |-> !fill_en);

endmodule

// File: tb/test_mmu_xlate.sv
module test_mmu_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        busy, rsp_valid, rsp_fault, mem_rd_en;
  logic [15:0] rsp_paddr, mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic        seg_wr_en = 1'b0;
  logic [2:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_base = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  int rd_cnt = 0, rsp_cnt = 0;
  logic [15:0] last_rd_addr = '0;
  logic [15:0] pt [256];

  always #2 clk = ~clk;

  mmu_xlate i_mmu_xlate (.*);

  // memory model: one-cycle halfword read, table indexed by addr[8:1]
  always @(posedge clk) begin
    if (mem_rd_en && mem_rd_valid) begin
      rd_cnt <= rd_cnt + 1;
      last_rd_addr <= mem_rd_addr;
    end
    mem_rd_valid <= mem_rd_en && !mem_rd_valid;
    mem_rd_data  <= pt[mem_rd_addr[8:1]];
    if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
  end

  function automatic [15:0] mk_pte(input [6:0] frame, input bit v, input [2:0] perm);
    return {frame, v, perm, 1'b1, 4'hA};   // dirty and aging set, must not matter
  endfunction
  function automatic [15:0] va(input [2:0] seg, input [3:0] pg, input [8:0] off);
    return {seg, pg, off};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input [31:0] act, input [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_rsp(output int lat);
    lat = 1;
    while (!rsp_valid && lat < 20) begin @(negedge clk); lat++; end
  endtask

  task automatic access(input [15:0] a, input [1:0] acc, input bit exp_walk,
                        input [15:0] exp_waddr, input bit exp_fault,
                        input [15:0] exp_pa, input string rq);
    int r0, lat;
    r0 = rd_cnt;
    @(negedge clk); req_valid = 1; req_vaddr = a; req_acc = acc;
    @(negedge clk); req_valid = 0;
    wait_rsp(lat);
    chk(rsp_valid, rq, "rsp_valid", rsp_valid, 1);
    chk(lat == (exp_walk ? 3 : 1), rq, "latency", lat, exp_walk ? 3 : 1);
    chk(rsp_fault == exp_fault, rq, "fault", rsp_fault, exp_fault);
    if (!exp_fault) chk(rsp_paddr == exp_pa, rq, "paddr", rsp_paddr, exp_pa);
    @(negedge clk);
    chk(rd_cnt - r0 == int'(exp_walk), rq, "reads", rd_cnt - r0, exp_walk);
    if (exp_walk) chk(last_rd_addr == exp_waddr, rq, "walk addr", last_rd_addr, exp_waddr);
  endtask

  task automatic seg_write(input [2:0] s, input [15:0] b);
    @(negedge clk); seg_wr_en = 1; seg_wr_sel = s; seg_wr_base = b;
    @(negedge clk); seg_wr_en = 0;
  endtask

  function automatic [15:0] wa(input [2:0] s, input [3:0] pg);
    return 16'(s) * 16'd32 + 16'(pg) * 16'd2;
  endfunction

  task automatic t_reset;  // R1
    chk(!busy && !rsp_valid && !mem_rd_en, "R1", "idle after reset",
        {busy, rsp_valid, mem_rd_en}, 0);
  endtask

  task automatic t_miss_hit;  // R1 R3 R4 R5 R2
    pt[19] = mk_pte(7'h4C, 1, 3'b111);
    access(va(1, 3, 9'h1A5), 2'b00, 1, wa(1, 3), 0, {7'h4C, 9'h1A5}, "R3_R4_R5");
    access(va(1, 3, 9'h007), 2'b01, 0, 0, 0, {7'h4C, 9'h007}, "R2");
  endtask

  task automatic t_invalid;  // R6
    pt[37] = mk_pte(7'h11, 0, 3'b111);
    access(va(2, 5, 9'h010), 2'b00, 1, wa(2, 5), 1, 0, "R6");
    access(va(2, 5, 9'h010), 2'b00, 1, wa(2, 5), 1, 0, "R6 repeat");
  endtask

  task automatic t_perm;  // R7 R4
    pt[48] = mk_pte(7'h22, 1, 3'b100);
    access(va(3, 0, 9'h003), 2'b00, 1, wa(3, 0), 0, {7'h22, 9'h003}, "R7 read ok");
    access(va(3, 0, 9'h003), 2'b01, 0, 0, 1, 0, "R7 write on hit");
    access(va(3, 0, 9'h003), 2'b10, 0, 0, 1, 0, "R7 exec on hit");
    access(va(3, 0, 9'h003), 2'b11, 0, 0, 1, 0, "R4 reserved code");
    pt[49] = mk_pte(7'h23, 1, 3'b010);
    access(va(3, 1, 9'h100), 2'b00, 1, wa(3, 1), 1, 0, "R7 read miss");
    access(va(3, 1, 9'h100), 2'b01, 1, wa(3, 1), 0, {7'h23, 9'h100}, "R7 write miss");
  endtask

  task automatic t_conflict;  // R8
    pt[67] = mk_pte(7'h30, 1, 3'b111);
    access(va(4, 3, 9'h000), 2'b00, 1, wa(4, 3), 0, {7'h30, 9'h000}, "R8 evict");
    access(va(1, 3, 9'h001), 2'b00, 1, wa(1, 3), 0, {7'h4C, 9'h001}, "R8 re-walk");
  endtask

  task automatic t_flush;  // R9
    pt[86]  = mk_pte(7'h55, 1, 3'b111);
    pt[103] = mk_pte(7'h66, 1, 3'b111);
    access(va(5, 6, 9'h000), 2'b00, 1, wa(5, 6), 0, {7'h55, 9'h000}, "R9 fill a");
    access(va(6, 7, 9'h000), 2'b00, 1, wa(6, 7), 0, {7'h66, 9'h000}, "R9 fill b");
    seg_write(5, 16'd160);
    access(va(5, 6, 9'h0AA), 2'b00, 1, wa(5, 6), 0, {7'h55, 9'h0AA}, "R9 flushed");
    access(va(6, 7, 9'h0BB), 2'b00, 0, 0, 0, {7'h66, 9'h0BB}, "R9 kept");
  endtask

  task automatic t_busy;  // R10
    int r0, c0, lat;
    pt[114] = mk_pte(7'h72, 1, 3'b111);
    pt[116] = mk_pte(7'h74, 1, 3'b111);
    r0 = rd_cnt; c0 = rsp_cnt;
    @(negedge clk); req_valid = 1; req_vaddr = va(7, 2, 0); req_acc = 0;
    @(negedge clk); req_vaddr = va(7, 4, 0);
    chk(busy, "R10", "busy during walk", busy, 1);
    @(negedge clk); req_valid = 0;
    wait_rsp(lat);
    chk(rsp_paddr == {7'h72, 9'h0}, "R10", "first served", rsp_paddr, {7'h72, 9'h0});
    repeat (4) @(negedge clk);
    chk(rsp_cnt - c0 == 1, "R10", "one response", rsp_cnt - c0, 1);
    chk(rd_cnt - r0 == 1, "R10", "one read", rd_cnt - r0, 1);
    access(va(7, 4, 9'h004), 2'b00, 1, wa(7, 4), 0, {7'h74, 9'h004}, "R10 not cached");
  endtask

  task automatic t_stale;  // R11
    int lat;
    pt[9]   = mk_pte(7'h09, 1, 3'b111);
    pt[137] = mk_pte(7'h3E, 1, 3'b111);
    @(negedge clk); req_valid = 1; req_vaddr = va(0, 9, 9'h012); req_acc = 0;
    @(negedge clk); req_valid = 0;
    seg_wr_en = 1; seg_wr_sel = 0; seg_wr_base = 16'd256;
    @(negedge clk); seg_wr_en = 0;
    wait_rsp(lat);
    chk(rsp_valid && !rsp_fault && rsp_paddr == {7'h09, 9'h012}, "R11", "old entry used",
        rsp_paddr, {7'h09, 9'h012});
    access(va(0, 9, 9'h013), 2'b00, 1, 16'd274, 0, {7'h3E, 9'h013}, "R11 not cached");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pt[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int s = 0; s < 8; s++) seg_write(3'(s), 16'(s * 32));
    t_miss_hit();
    t_invalid();
    t_perm();
    t_conflict();
    t_flush();
    t_busy();
    t_stale();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule